// File: doc/BRIEF.md
# Packed-Decimal Byte Subtract and Negate Unit

This block takes two bytes that each hold two binary-coded decimal digits and produces their decimal difference, or the decimal negation of a single byte (zero minus the byte). An extend bit from the caller acts as a borrow-in, so several bytes can be chained from least to most significant to handle long decimal numbers. Beside the result byte it produces a five-bit condition set of extend, negative, zero, overflow and carry.

Which operation to run is decoded from a 16-bit operation word that arrives with the operands. The caller raises `start` for one cycle with the word, the operands and the current flags. On the next clock edge the unit registers the result and the new flags, and pulses `done` for one cycle. An operation word that matches neither pattern is dropped. It causes no pulse and does not change the outputs. The zero flag can only be cleared, never set. The caller presets it to 1 before a multi-byte chain, and it then reads 1 at the end only if every byte of the chain was zero.

Top module: `bcd_sub_unit`

## Requirements
- R1: When `(opcode & 16'hF1F0) == 16'h8100` and `start` is high, the unit computes `dst_byte - src_byte - X` in two-digit packed decimal. X is `flags_in[4]`. The result appears on `result`, and every digit is 0..9 when both operands hold valid digits.
- R2: When `(opcode & 16'hFFC0) == 16'h4800` and `start` is high, the unit computes `0 - dst_byte - X` in packed decimal. `src_byte` is not used in this case.
- R3: A `start` with an operation word matching neither pattern raises no `done`. `result` and `flags_out` keep their previous values.
- R4: `done` is high for exactly the one cycle after each clock edge at which `start` was sampled with a matching operation word, and is low otherwise.
- R5: Flag bits are ordered X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0, in both `flags_in` and `flags_out`. X and C are both set exactly when the decimal difference borrowed, meaning it fell below zero and wrapped by 100.
- R6: N equals bit 7 of the result byte.
- R7: Z out equals Z in when the result byte is zero, and is 0 otherwise. Z is never set by the unit.
- R8: V is set when bit 7 of the minuend and bit 7 of the subtrahend differ, and bit 7 of the result differs from bit 7 of the minuend. In the negate case the minuend is zero and the subtrahend is `dst_byte`.
- R9: A borrow out of the low digit is corrected even when the low-digit difference is negative. For example, 0x10 − 0x01 with X=0 gives 0x09 with no borrow.
- R10: If `rst_n` is low at a clock edge, `result`, `flags_out` and `done` are cleared at that edge, regardless of `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sample inputs and run this cycle |
| opcode | input | 16 | Operation word to decode |
| src_byte | input | 8 | Subtrahend for subtract |
| dst_byte | input | 8 | Minuend for subtract; operand for negate |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| result | output | 8 | Registered decimal result |
| flags_out | output | 5 | Registered new flags {X,N,Z,V,C} |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The digit-range check relies on the operands holding only decimal digits. It is conditioned on that, because non-decimal inputs give unspecified digits. All other assertions rely only on `start`, `opcode` and `flags_in` being driven, not X, during cycles when reset is released. The stimulus drives every input to a defined value from time zero and builds operands only from digits 0..9. Ignored operation words are still sent with `start` high, so the hold and no-pulse properties are actually exercised.

// File: rtl/bcd_sub_pkg.sv
// Shared definitions for the packed-decimal subtract/negate unit.
// Assumes flag vectors are ordered {X,N,Z,V,C} from MSB to LSB.
package bcd_sub_pkg;
    localparam int FLAG_W = 5;
    localparam int FLG_X  = 4;
    localparam int FLG_N  = 3;
    localparam int FLG_Z  = 2;
    localparam int FLG_V  = 1;
    localparam int FLG_C  = 0;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_SUB  = 2'd1,
        OPK_NEG  = 2'd2
    } op_kind_e;
endpackage

// File: rtl/bcd_op_decode.sv
// Classifies an operation word as decimal subtract, decimal negate, or none.
// Assumes the two match patterns never overlap; subtract is checked first.
module bcd_op_decode
    import bcd_sub_pkg::*;
#(
    parameter int            OPC_W    = 16,
    parameter logic [15:0]   SUB_MASK = 16'hF1F0,
    parameter logic [15:0]   SUB_PAT  = 16'h8100,
    parameter logic [15:0]   NEG_MASK = 16'hFFC0,
    parameter logic [15:0]   NEG_PAT  = 16'h4800
) (
    input  logic [OPC_W-1:0] opcode,
    output op_kind_e         kind
);
    localparam logic [OPC_W-1:0] SM = OPC_W'(SUB_MASK);
    localparam logic [OPC_W-1:0] SP = OPC_W'(SUB_PAT);
    localparam logic [OPC_W-1:0] NM = OPC_W'(NEG_MASK);
    localparam logic [OPC_W-1:0] NP = OPC_W'(NEG_PAT);

    // Pattern match on masked operation word.
    always_comb begin
        if ((opcode & SM) == SP)      kind = OPK_SUB;
        else if ((opcode & NM) == NP) kind = OPK_NEG;
        else                          kind = OPK_NONE;
    end
endmodule

// File: rtl/bcd_sub_core.sv
// Two-digit packed-decimal subtractor with borrow in/out and binary overflow.
// Works digit by digit in a wrapping word two bits wider than the byte, so a
// negative intermediate appears as a large unsigned value and is corrected by
// the same compare as an out-of-range one. Assumes operands hold digits 0..9.
module bcd_sub_core #(
    parameter int NIB = 4
) (
    input  logic [2*NIB-1:0] minuend,
    input  logic [2*NIB-1:0] subtrahend,
    input  logic             borrow_in,
    output logic [2*NIB-1:0] diff,
    output logic             borrow_out,
    output logic             ovf
);
    localparam int BYTE   = 2 * NIB;
    localparam int WIDE   = BYTE + 2;
    localparam int GAP    = (1 << NIB) - 10;
    localparam int DMAX   = 9;
    localparam int BMAX   = (DMAX << NIB) | DMAX;

    logic [WIDE-1:0] lo_raw, lo_fix, hi_m, hi_s, sum_raw, sum_fix;

    // Low digit difference with borrow, then digit correction.
    always_comb begin
        lo_raw = WIDE'(minuend[NIB-1:0]) - WIDE'(subtrahend[NIB-1:0])
               - WIDE'(borrow_in);
        lo_fix = (lo_raw > WIDE'(DMAX)) ? lo_raw - WIDE'(GAP) : lo_raw;
    end

    // Fold in high digits and correct the whole byte.
    always_comb begin
        hi_m    = WIDE'({minuend[BYTE-1:NIB], {NIB{1'b0}}});
        hi_s    = WIDE'({subtrahend[BYTE-1:NIB], {NIB{1'b0}}});
        sum_raw = lo_fix + hi_m - hi_s;
        sum_fix = (sum_raw > WIDE'(BMAX)) ? sum_raw - WIDE'(GAP << NIB) : sum_raw;
    end

    // Outputs: byte, borrow from bits above the byte, binary overflow.
    always_comb begin
        diff       = sum_fix[BYTE-1:0];
        borrow_out = |sum_fix[WIDE-1:BYTE];
        ovf        = (minuend[BYTE-1] ^ subtrahend[BYTE-1])
                   & (diff[BYTE-1] ^ minuend[BYTE-1]);
    end
endmodule

// File: rtl/bcd_sub_unit.sv
// Top: decodes the operation word, routes operands for subtract or negate,
// and registers the result, flags and a one-cycle done pulse.
// Assumes synchronous active-low reset and flags ordered {X,N,Z,V,C}.
module bcd_sub_unit
    import bcd_sub_pkg::*;
#(
    parameter int          OPC_W    = 16,
    parameter int          NIB      = 4,
    parameter logic [15:0] SUB_MASK = 16'hF1F0,
    parameter logic [15:0] SUB_PAT  = 16'h8100,
    parameter logic [15:0] NEG_MASK = 16'hFFC0,
    parameter logic [15:0] NEG_PAT  = 16'h4800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [2*NIB-1:0]   src_byte,
    input  logic [2*NIB-1:0]   dst_byte,
    input  logic [FLAG_W-1:0]  flags_in,
    output logic [2*NIB-1:0]   result,
    output logic [FLAG_W-1:0]  flags_out,
    output logic               done
);
    localparam int BYTE = 2 * NIB;

    op_kind_e          kind;
    logic [BYTE-1:0]   op_m, op_s, diff;
    logic              borrow, ovf;
    logic [FLAG_W-1:0] flags_nx;

    bcd_op_decode #(
        .OPC_W(OPC_W), .SUB_MASK(SUB_MASK), .SUB_PAT(SUB_PAT),
        .NEG_MASK(NEG_MASK), .NEG_PAT(NEG_PAT)
    ) u_dec (
        .opcode(opcode),
        .kind  (kind)
    );

    // Negate forces a zero minuend and takes dst_byte as subtrahend.
    always_comb begin
        op_m = (kind == OPK_NEG) ? '0 : dst_byte;
        op_s = (kind == OPK_NEG) ? dst_byte : src_byte;
    end

    bcd_sub_core #(.NIB(NIB)) u_core (
        .minuend   (op_m),
        .subtrahend(op_s),
        .borrow_in (flags_in[FLG_X]),
        .diff      (diff),
        .borrow_out(borrow),
        .ovf       (ovf)
    );

    // Next flag set: borrow into X and C, sticky zero.
    always_comb begin
        flags_nx        = '0;
        flags_nx[FLG_X] = borrow;
        flags_nx[FLG_C] = borrow;
        flags_nx[FLG_N] = diff[BYTE-1];
        flags_nx[FLG_Z] = flags_in[FLG_Z] & (diff == '0);
        flags_nx[FLG_V] = ovf;
    end

    // Output registers: load on a decoded start, pulse done once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            flags_out <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && (kind != OPK_NONE)) begin
                result    <= diff;
                flags_out <= flags_nx;
                done      <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcd_sub_unit_chk.sv
// Property checker for bcd_sub_unit, attached by bind. Observes ports only.
// Assumes inputs are driven (not X) whenever rst_n is high.
module bcd_sub_unit_chk
    import bcd_sub_pkg::*;
#(
    parameter int          OPC_W    = 16,
    parameter int          NIB      = 4,
    parameter logic [15:0] SUB_MASK = 16'hF1F0,
    parameter logic [15:0] SUB_PAT  = 16'h8100,
    parameter logic [15:0] NEG_MASK = 16'hFFC0,
    parameter logic [15:0] NEG_PAT  = 16'h4800
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [OPC_W-1:0]   opcode,
    input logic [2*NIB-1:0]   src_byte,
    input logic [2*NIB-1:0]   dst_byte,
    input logic [FLAG_W-1:0]  flags_in,
    input logic [2*NIB-1:0]   result,
    input logic [FLAG_W-1:0]  flags_out,
    input logic               done
);
    localparam int BYTE = 2 * NIB;
    logic is_sub, is_neg, known, src_dec, dst_dec, res_dec;

    // Operation word classification and digit validity seen at the ports.
    always_comb begin
        is_sub  = (opcode & OPC_W'(SUB_MASK)) == OPC_W'(SUB_PAT);
        is_neg  = (opcode & OPC_W'(NEG_MASK)) == OPC_W'(NEG_PAT);
        known   = is_sub | is_neg;
        src_dec = (src_byte[NIB-1:0] <= NIB'(9)) && (src_byte[BYTE-1:NIB] <= NIB'(9));
        dst_dec = (dst_byte[NIB-1:0] <= NIB'(9)) && (dst_byte[BYTE-1:NIB] <= NIB'(9));
        res_dec = (result[NIB-1:0] <= NIB'(9)) && (result[BYTE-1:NIB] <= NIB'(9));
    end

    assert_done_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    assert_no_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    assert_ignored_no_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !known) |=> !done);
    assert_ignored_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !known) |=> ($stable(result) && $stable(flags_out)));
    assert_borrow_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FLG_X] == flags_out[FLG_C]));
    assert_neg_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FLG_N] == result[BYTE-1]));
    assert_zero_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && known && !flags_in[FLG_Z]) |=> !flags_out[FLG_Z]);
    assert_digits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && known && src_dec && dst_dec) |=> res_dec);
endmodule

bind bcd_sub_unit bcd_sub_unit_chk #(
    .OPC_W(OPC_W), .NIB(NIB), .SUB_MASK(SUB_MASK), .SUB_PAT(SUB_PAT),
    .NEG_MASK(NEG_MASK), .NEG_PAT(NEG_PAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .src_byte(src_byte), .dst_byte(dst_byte), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .done(done)
);

// File: tb/test_bcd_sub_unit.sv
`timescale 1ns/1ps
module test_bcd_sub_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = 16'h0000;
    logic [7:0]  src_byte = 8'h00;
    logic [7:0]  dst_byte = 8'h00;
    logic [4:0]  flags_in = 5'h00;
    logic [7:0]  result;
    logic [4:0]  flags_out;
    logic        done;

    int total = 0;
    int bad   = 0;
    logic [7:0] last_res = 8'h00;
    logic [4:0] last_flg = 5'h00;

    typedef struct {
        logic [7:0] res;
        logic [4:0] flg;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bcd_sub_unit i_bcd_sub_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .src_byte(src_byte), .dst_byte(dst_byte), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: decimal arithmetic on digit values, flags per requirements.
    function automatic logic [12:0] model(input bit neg, input logic [7:0] s,
                                          input logic [7:0] d, input logic [4:0] f);
        logic [7:0] m, sb, r;
        int mv, sv, dv;
        bit br, z, v;
        m  = neg ? 8'h00 : d;
        sb = neg ? d : s;
        mv = int'(m[7:4]) * 10 + int'(m[3:0]);
        sv = int'(sb[7:4]) * 10 + int'(sb[3:0]);
        dv = mv - sv - int'(f[4]);
        br = (dv < 0);
        if (br) dv += 100;
        r  = {4'(dv / 10), 4'(dv % 10)};
        z  = f[2] && (r == 8'h00);
        v  = (m[7] != sb[7]) && (r[7] != m[7]);
        return {r, br, r[7], z, v, br};
    endfunction

    // Driver: one start pulse, expected item into scoreboard, then idle check.
    task automatic run_op(input logic [15:0] op, input logic [7:0] s,
                          input logic [7:0] d, input logic [4:0] f,
                          input int kind, input string tag);
        logic [12:0] e;
        @(negedge clk);
        opcode = op; src_byte = s; dst_byte = d; flags_in = f; start = 1'b1;
        if (kind != 0) begin
            e = model(kind == 2, s, d, f);
            sb_q.push_back('{e[12:5], e[4:0], tag});
            last_res = e[12:5];
            last_flg = e[4:0];
        end
        @(negedge clk);
        start = 1'b0;
        if (kind == 0) begin
            check(done == 1'b0, "R3 done on ignored op", int'(done), 0);
            check(result == last_res, "R3 result held", int'(result), int'(last_res));
            check(flags_out == last_flg, "R3 flags held", int'(flags_out), int'(last_flg));
        end
        @(negedge clk);
        check(done == 1'b0, "R4 pulse one cycle", int'(done), 0);
    endtask

    // Monitor: pop and compare each completed result.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", 1, 0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(result == it.res, {it.tag, " result"}, int'(result), int'(it.res));
                check(flags_out == it.flg, {it.tag, " flags"}, int'(flags_out), int'(it.flg));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset holds everything clear even with a valid start.
        opcode = 16'h8100; src_byte = 8'h01; dst_byte = 8'h00; start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(result == 8'h00, "R10 reset result", int'(result), 0);
        check(flags_out == 5'h00, "R10 reset flags", int'(flags_out), 0);
        check(done == 1'b0, "R10 reset done", int'(done), 0);
        start = 1'b0;
        rst_n = 1'b1;

        // R1 plain subtract, Z in cleared by nonzero result (R7).
        run_op(16'h8100, 8'h12, 8'h45, 5'b00100, 1, "R1 45-12");
        // R5 borrow: 12-45 -> 67 with X,C.
        run_op(16'h8F09, 8'h45, 8'h12, 5'b00000, 1, "R5 12-45");
        // R9 low-digit borrow corrected.
        run_op(16'h8100, 8'h01, 8'h10, 5'b00000, 1, "R9 10-01");
        // R5 borrow-in on zero operands gives 99.
        run_op(16'h8100, 8'h00, 8'h00, 5'b10000, 1, "R5 00-00-X");
        // R7 zero result keeps Z set, and keeps Z clear.
        run_op(16'h8100, 8'h50, 8'h50, 5'b00100, 1, "R7 Z kept set");
        run_op(16'h8100, 8'h50, 8'h50, 5'b00000, 1, "R7 Z kept clear");
        // R8 overflow: 80-01 -> 79.
        run_op(16'h8100, 8'h01, 8'h80, 5'b00000, 1, "R8 80-01");
        // R6 negative bit from result: 95-05 -> 90.
        run_op(16'h8100, 8'h05, 8'h95, 5'b00000, 1, "R6 95-05");
        // R2 negate cases; src_byte is unused.
        run_op(16'h4800, 8'h77, 8'h01, 5'b00000, 2, "R2 neg 01");
        run_op(16'h4838, 8'h33, 8'h00, 5'b00100, 2, "R2 neg 00");
        run_op(16'h4805, 8'h00, 8'h00, 5'b10100, 2, "R2 neg 00 X");
        run_op(16'h4800, 8'h00, 8'h99, 5'b00000, 2, "R2 neg 99");
        // R3 ignored operation words.
        run_op(16'hC100, 8'h11, 8'h22, 5'b10000, 0, "R3 add word");
        run_op(16'h8140, 8'h11, 8'h22, 5'b10000, 0, "R3 near sub");
        run_op(16'h4840, 8'h11, 8'h22, 5'b10000, 0, "R3 near neg");
        // R1 sweep across digits and borrow-in.
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j += 3) begin
                logic [7:0] a, b;
                a = {4'(i), 4'((i * 7) % 10)};
                b = {4'(j), 4'((j * 3 + 1) % 10)};
                run_op(16'h8100, b, a, {1'(i % 2), 2'b00, 1'(j % 2), 1'b0}, 1, "R1 sweep");
            end
        end
        // R4 back-to-back starts each give a pulse.
        @(negedge clk);
        opcode = 16'h8100; src_byte = 8'h01; dst_byte = 8'h03; flags_in = 5'h00; start = 1'b1;
        sb_q.push_back('{8'h02, 5'b00000, "R4 b2b first"});
        @(negedge clk);
        dst_byte = 8'h05;
        sb_q.push_back('{8'h04, 5'b00000, "R4 b2b second"});
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R4 done after b2b", int'(done), 0);
        check(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
        // R10 reset mid-run clears outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check(result == 8'h00 && flags_out == 5'h00, "R10 mid-run reset",
              int'({result, flags_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule